// File: doc/BRIEF.md
# Carry-Less Multiply Engine With Operand Half Selection

This block forms the product of two polynomials over GF(2). Each input operand is 128 bits wide. A selector byte picks one 64-bit half of each operand. The engine then multiplies the two halves with XOR accumulation, so no carry ever moves between bit positions, and it returns the full 128-bit product. Bit i of an operand or of the result is the coefficient of X^i, so bit 0 is the constant term. Typical uses are hashing in Galois-field authenticated modes and folding steps in CRC computation. The selector lets software form the four cross products of two 128-bit values without shuffling them first.

The engine is iterative. When an operand set is accepted, the chosen half of the first operand becomes the multiplicand and the chosen half of the second becomes the multiplier. On each busy cycle the engine consumes STEP_BITS multiplier bits, lowest first. For each set bit k it XORs the multiplicand, shifted left by k, into an accumulator. The input side is a valid/ready handshake. `in_ready` is high only while the engine is idle, and a transfer happens on a clock edge where `in_valid` and `in_ready` are both high. The output side is also valid/ready. Once a result is ready, `out_valid` stays high and `out_prod` holds steady until a clock edge where `out_ready` is high. While a result waits, no new input is accepted, so back-pressure on the output stalls the input.

Top module: `clmul_unit`

## Requirements
- R1: `out_prod` equals the GF(2) polynomial product of the selected halves. Bit i is the coefficient of X^i, and partial products combine by XOR with no carries (for example 0x3 times 0x3 gives 0x5).
- R2: Selector 0x00 multiplies bits [63:0] of `in_op_a` by bits [63:0] of `in_op_b`.
- R3: Selector 0x01 multiplies bits [127:64] of `in_op_a` by bits [63:0] of `in_op_b`.
- R4: Selector 0x10 multiplies bits [63:0] of `in_op_a` by bits [127:64] of `in_op_b`.
- R5: Selector 0x11 multiplies bits [127:64] of both operands.
- R6: Only selector bit 0 (half of `in_op_a`, 1 = upper) and bit 4 (half of `in_op_b`, 1 = upper) matter. The other six bits have no effect on the result.
- R7: Bit 127 of `out_prod` is always 0 while `out_valid` is high.
- R8: A zero selected half gives a zero product. A selected half equal to 1 gives the other selected half, zero-extended to 128 bits.
- R9: `out_valid` rises exactly HALF_W/STEP_BITS clock edges after the accepting edge. `in_ready` is low from the accepting edge until the edge where the result is taken, and `in_valid` is ignored during that time.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` does not change.
- R11: During and just after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Engine idle, operand set will be taken |
| in_op_a | input | 128 | First operand; one half becomes the multiplicand |
| in_op_b | input | 128 | Second operand; one half becomes the multiplier |
| in_sel | input | 8 | Half selector; bit 0 for `in_op_a`, bit 4 for `in_op_b` |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 128 | Carry-less product |

## Verification
The bench builds the block with its defaults: 64-bit halves, one multiplier bit per cycle, and selector positions 0 and 4. With these values the full 64-cycle latency is exercised, every multiplier bit passes through its own step of the shift path, and all four half pairings come from real selector bytes. A per-clock model predicts the handshake and the product. This reaches stalled outputs held for several cycles, input offers made while the engine is busy, selector bytes with junk in the unused bits, the identity and zero operands, and the all-ones case that reaches the top degree 126.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  // Control sequencing of the iterative engine
  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_RUN  = 2'd1,
    CM_HOLD = 2'd2
  } cm_state_e;

endpackage

// File: rtl/clmul_half_pick.sv
// Chooses the upper or lower half of a double-width operand.
module clmul_half_pick #(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] op_i,
  input  logic                upper_i,
  output logic [HALF_W-1:0]   half_o
);

  assign half_o = upper_i ? op_i[2*HALF_W-1:HALF_W] : op_i[HALF_W-1:0];

endmodule

// File: rtl/clmul_step.sv
// One iteration: folds STEP_BITS multiplier bits into the accumulator.
module clmul_step #(
  parameter int PROD_W    = 128,
  parameter int STEP_BITS = 1
) (
  input  logic [PROD_W-1:0]    acc_i,
  input  logic [PROD_W-1:0]    mcand_i,
  input  logic [STEP_BITS-1:0] bits_i,
  output logic [PROD_W-1:0]    acc_o
);

  logic [PROD_W-1:0] chain [STEP_BITS+1];

  assign chain[0] = acc_i;

  for (genvar j = 0; j < STEP_BITS; j++) begin : g_fold
    // partial products merge by XOR: no carry between columns
    assign chain[j+1] = chain[j] ^ (bits_i[j] ? (mcand_i << j) : '0);
  end

  assign acc_o = chain[STEP_BITS];

endmodule

// File: rtl/clmul_ctrl.sv
// Handshake and iteration sequencing.
module clmul_ctrl
  import clmul_pkg::*;
#(
  parameter int STEPS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_en,
  output logic step_en
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  cm_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign in_ready  = (state_q == CM_IDLE);
  assign out_valid = (state_q == CM_HOLD);
  assign load_en   = in_ready && in_valid;
  assign step_en   = (state_q == CM_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CM_IDLE: begin
        if (in_valid) begin
          state_d = CM_RUN;
          cnt_d   = '0;
        end
      end
      CM_RUN: begin
        if (cnt_q == LAST) state_d = CM_HOLD;
        else               cnt_d   = cnt_q + 1'b1;
      end
      CM_HOLD: begin
        if (out_ready) state_d = CM_IDLE;
      end
      default: state_d = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CM_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/clmul_unit.sv
// Iterative carry-less multiplier with per-operand half selection.
// HALF_W must be a multiple of STEP_BITS.
module clmul_unit #(
  parameter int HALF_W    = 64,
  parameter int SEL_W     = 8,
  parameter int SEL_A_POS = 0,
  parameter int SEL_B_POS = 4,
  parameter int STEP_BITS = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*HALF_W-1:0]   in_op_a,
  input  logic [2*HALF_W-1:0]   in_op_b,
  input  logic [SEL_W-1:0]      in_sel,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*HALF_W-1:0]   out_prod
);

  localparam int PROD_W = 2 * HALF_W;
  localparam int STEPS  = HALF_W / STEP_BITS;

  logic [HALF_W-1:0] a_half, b_half;
  logic              load_en, step_en;
  logic [PROD_W-1:0] mcand_q, acc_q, acc_nxt;
  logic [HALF_W-1:0] mplier_q;

  // selector bits other than the two pick positions are don't-care
  logic unused_sel;
  assign unused_sel = ^in_sel;

  clmul_half_pick #(.HALF_W(HALF_W)) u_pick_a (
    .op_i    (in_op_a),
    .upper_i (in_sel[SEL_A_POS]),
    .half_o  (a_half)
  );

  clmul_half_pick #(.HALF_W(HALF_W)) u_pick_b (
    .op_i    (in_op_b),
    .upper_i (in_sel[SEL_B_POS]),
    .half_o  (b_half)
  );

  clmul_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_en   (load_en),
    .step_en   (step_en)
  );

  clmul_step #(.PROD_W(PROD_W), .STEP_BITS(STEP_BITS)) u_step (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .bits_i  (mplier_q[STEP_BITS-1:0]),
    .acc_o   (acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_en) begin
      mcand_q  <= PROD_W'(a_half);
      mplier_q <= b_half;
      acc_q    <= '0;
    end else if (step_en) begin
      acc_q    <= acc_nxt;
      mcand_q  <= mcand_q << STEP_BITS;
      mplier_q <= mplier_q >> STEP_BITS;
    end
  end

  assign out_prod = acc_q;

endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk #(
  parameter int HALF_W    = 64,
  parameter int STEP_BITS = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*HALF_W-1:0] out_prod
);

  localparam int LAT = HALF_W / STEP_BITS;
  localparam int LW  = $clog2(LAT + 2);
  localparam logic [LW-1:0] LMAX = '1;

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_q <= '0;
    else if (in_valid && in_ready)       lat_q <= '0;
    else if (!out_valid && lat_q != LMAX) lat_q <= lat_q + 1'b1;
  end

  // R7
  msb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_prod[2*HALF_W-1]);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LW'(LAT)));

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid));

endmodule

bind clmul_unit clmul_unit_chk #(.HALF_W(HALF_W), .STEP_BITS(STEP_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/sim_clmul_unit.sv
module sim_clmul_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_op_a = '0;
  logic [127:0] in_op_b = '0;
  logic [7:0]   in_sel = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_prod;

  int checks = 0;
  int errors = 0;

  // model: 0 idle, 1 running, 2 holding result
  int           m_state = 0;
  int           m_rem = 0;
  logic [127:0] m_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clmul_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op_a   (in_op_a),
    .in_op_b   (in_op_b),
    .in_sel    (in_sel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_prod  (out_prod)
  );

  function automatic logic [127:0] gf2_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] r = '0;
    for (int i = 0; i < 64; i++)
      if (y[i]) r = r ^ ({64'd0, x} << i);
    return r;
  endfunction

  function automatic logic [127:0] ref_prod(input logic [127:0] a, input logic [127:0] b,
                                            input logic [7:0] s);
    logic [63:0] ah, bh;
    ah = s[0] ? a[127:64] : a[63:0];
    bh = s[4] ? b[127:64] : b[63:0];
    return gf2_mul(ah, bh);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // advance one clock using the inputs now driven, then compare at the falling edge
  task automatic step();
    case (m_state)
      0: if (in_valid) begin
           m_state = 1;
           m_rem   = LAT;
           m_res   = ref_prod(in_op_a, in_op_b, in_sel);
         end
      1: begin
           m_rem--;
           if (m_rem == 0) m_state = 2;
         end
      default: if (out_ready) m_state = 0;
    endcase
    @(negedge clk);
    chk(in_ready == (m_state == 0), "R9", "in_ready", 128'(in_ready), 128'(m_state == 0));
    chk(out_valid == (m_state == 2), "R9", "out_valid", 128'(out_valid), 128'(m_state == 2));
    if (m_state == 2) chk(out_prod == m_res, "R1", "product", out_prod, m_res);
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [7:0] s,
                        input logic [127:0] exp, input string req, input int hold, input bit junk);
    in_op_a  = a;
    in_op_b  = b;
    in_sel   = s;
    in_valid = 1'b1;
    step();
    if (junk) begin
      // R9: offers during the busy phase must be ignored
      in_op_a = ~a;
      in_op_b = ~b;
      in_sel  = ~s;
    end else begin
      in_valid = 1'b0;
    end
    for (int i = 0; i < LAT + 4 && !out_valid; i++) step();
    in_valid = 1'b0;
    chk(out_valid, "R9", "result arrived", 128'(out_valid), 128'd1);
    chk(out_prod == exp, req, "selected product", out_prod, exp);
    chk(!out_prod[127], "R7", "top bit", 128'(out_prod[127]), 128'd0);
    for (int i = 0; i < hold; i++) step();
    if (hold > 0) chk(out_valid && out_prod == exp, "R10", "held result", out_prod, exp);
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk(in_ready, "R9", "idle after take", 128'(in_ready), 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    // R11
    chk(in_ready && !out_valid, "R11", "reset idle", {in_ready, out_valid}, 128'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R11", "after reset", {in_ready, out_valid}, 128'b10);

    // R1 known small product: (X+1)^2 = X^2+1
    run_op(128'h3, 128'h3, 8'h00, 128'h5, "R1", 0, 1'b0);

    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    run_op(a, b, 8'h00, gf2_mul(a[63:0],   b[63:0]),   "R2", 0, 1'b0);
    run_op(a, b, 8'h01, gf2_mul(a[127:64], b[63:0]),   "R3", 3, 1'b0);
    run_op(a, b, 8'h10, gf2_mul(a[63:0],   b[127:64]), "R4", 0, 1'b1);
    run_op(a, b, 8'h11, gf2_mul(a[127:64], b[127:64]), "R5", 5, 1'b1);

    // R6: junk in unused selector bits
    run_op(a, b, 8'hEE, gf2_mul(a[63:0],   b[63:0]),   "R6", 0, 1'b0);
    run_op(a, b, 8'hFF, gf2_mul(a[127:64], b[127:64]), "R6", 0, 1'b0);
    run_op(a, b, 8'h5A, gf2_mul(a[63:0],   b[127:64]), "R6", 0, 1'b0);
    run_op(a, b, 8'hA3, gf2_mul(a[127:64], b[63:0]),   "R6", 0, 1'b0);

    // R8: zero and identity
    run_op({64'hFFFF_0000_1234_5678, 64'd0}, b, 8'h00, 128'd0, "R8", 0, 1'b0);
    run_op(a, {64'd1, 64'hDEAD_BEEF_0000_0001}, 8'h10, {64'd0, a[63:0]}, "R8", 0, 1'b0);
    run_op({64'd1, 64'd0}, b, 8'h11, {64'd0, b[127:64]}, "R8", 0, 1'b0);

    // R7: all-ones reaches degree 126
    run_op('1, '1, 8'h00, gf2_mul('1, '1), "R7", 2, 1'b0);

    // R1 random patterns
    for (int n = 0; n < 16; n++) begin
      logic [7:0] s;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      s = 8'($urandom);
      run_op(a, b, s, ref_prod(a, b, s), "R1", n % 3, n[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule